// File: doc/BRIEF.md
# External Interrupt Edge and Level Detector

This block watches four maskable interrupt pins and one non-maskable pin. Each pin is first brought into the clock domain, and then its configured trigger condition is checked. The trigger condition can be a rising edge, a falling edge, a high level, or both edges. When a source triggers, the block latches a request flag for that source. A configuration register chooses the trigger condition for each pin. Input 0 is the only input that can run in level mode. The non-maskable pin can be armed to trigger on both of its edges.

Software removes a pending request by writing that source's vector number into a shared, write-only clear register. Each source does not have its own clear bit. The block also presents the vector of the highest-priority pending source, so that the surrounding interrupt logic can pick it up.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset, `req_flags` is 0, `top_valid` is 0, `top_vector` is 0, and every configuration bit is 0.
- R2: Each pin passes through two synchronizing flops before detection. The matching flag rises on the third rising clock edge, counted from the first edge that samples the new pin level.
- R3: Configuration bits 2, 3, 4 and 5 select the polarity for inputs 0, 1, 2 and 3. A value of 0 triggers on a rising edge and a value of 1 triggers on a falling edge. An edge of the other polarity sets nothing.
- R4: When configuration bit 1 is 1, input 0 is in level mode. A synchronized high level sets flag 0 on every cycle, and a clear has no effect while the pin stays high. After the pin goes low, flag 0 stays set until it is cleared.
- R5: By default the non-maskable pin (flag bit 4) triggers only on its falling edge. When configuration bit 0 is 1, its rising edge also triggers it.
- R6: A write to the clear register with bits 5:0 equal to a source's vector clears that flag on the same edge. The vectors are: non-maskable 0x02, input 0 0x0A, input 1 0x0B, input 2 0x0C, input 3 0x0D. A value that matches no vector changes nothing.
- R7: A clear write with bit 7 or bit 6 set is ignored completely.
- R8: If a trigger and a clear for the same source occur on the same clock edge, the flag ends up set.
- R9: Detection is held off until the synchronizers and the previous-sample register hold real pin values. A pin that is high through reset release raises no request.
- R10: `top_vector` gives the vector of the highest-priority pending flag. The order is non-maskable first, then inputs 0, 1, 2 and 3. `top_valid` is 1 exactly when some flag is set. When no flag is set, `top_vector` is 0.
- R11: In edge mode a flag stays set after the pin returns to its idle level, until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 4 | Maskable interrupt pins, asynchronous |
| nmi_in | input | 1 | Non-maskable interrupt pin, asynchronous |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 6 | Configuration: bit0 both-edge enable for the non-maskable pin, bit1 level mode for input 0, bits 5:2 falling-edge select for inputs 0 to 3 |
| clr_we | input | 1 | Clear register write strobe |
| clr_wdata | input | 8 | Clear value: bits 5:0 vector, bits 7:6 must be 0 |
| req_flags | output | 5 | Pending flags: bits 3:0 for inputs 0 to 3, bit 4 for the non-maskable pin |
| top_valid | output | 1 | At least one flag is pending |
| top_vector | output | 6 | Vector of the highest-priority pending flag |

## Verification
The bench holds a pin high through reset release. A design that took its first sample against a reset value of 0 would latch a phantom rising-edge request at that point. The bench also lands a new edge on the same clock edge as a clear for that source. If clear took priority, the interrupt would be lost without any sign. In level mode, the bench clears input 0 while the pin is still high and expects the flag to remain set. It also sends clear values that carry non-zero upper bits, and values that match no vector. A loose decoder would drop a flag it should have kept. Finally, the bench sweeps through polarity settings and mixed pin patterns. This exposes swapped polarity bits, a non-maskable pin that fires on a rising edge by default, and a wrong priority order.

// File: rtl/ext_irq_detect.sv
module ext_irq_detect #(
  parameter logic [5:0] VEC_NMI  = 6'h02,
  parameter logic [5:0] VEC_INT0 = 6'h0A,
  parameter logic [5:0] VEC_INT1 = 6'h0B,
  parameter logic [5:0] VEC_INT2 = 6'h0C,
  parameter logic [5:0] VEC_INT3 = 6'h0D
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] irq_in,
  input  logic       nmi_in,
  input  logic       cfg_we,
  input  logic [5:0] cfg_wdata,
  input  logic       clr_we,
  input  logic [7:0] clr_wdata,
  output logic [4:0] req_flags,
  output logic       top_valid,
  output logic [5:0] top_vector
);

  localparam int NSRC = 5;

  logic [NSRC-1:0] s1, s2, prev;
  logic [1:0]      warm;
  logic [5:0]      mode;
  logic [NSRC-1:0] hit, set_ev, clr_hit;

  wire ready = (warm == 2'd3);
  wire [NSRC-1:0] rise = s2 & ~prev;
  wire [NSRC-1:0] fall = ~s2 & prev;
  wire clr_ok = clr_we && (clr_wdata[7:6] == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      prev <= '0;
      warm <= '0;
      mode <= '0;
    end else begin
      s1   <= {nmi_in, irq_in};
      s2   <= s1;
      prev <= s2;
      if (!ready) warm <= warm + 2'd1;
      if (cfg_we) mode <= cfg_wdata;
    end
  end

  always_comb begin
    hit[0] = mode[1] ? s2[0] : (mode[2] ? fall[0] : rise[0]);
    for (int i = 1; i < 4; i++)
      hit[i] = mode[2+i] ? fall[i] : rise[i];
    hit[4] = fall[4] | (mode[0] & rise[4]);
  end

  assign set_ev = ready ? hit : '0;

  assign clr_hit[0] = clr_ok && (clr_wdata[5:0] == VEC_INT0);
  assign clr_hit[1] = clr_ok && (clr_wdata[5:0] == VEC_INT1);
  assign clr_hit[2] = clr_ok && (clr_wdata[5:0] == VEC_INT2);
  assign clr_hit[3] = clr_ok && (clr_wdata[5:0] == VEC_INT3);
  assign clr_hit[4] = clr_ok && (clr_wdata[5:0] == VEC_NMI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_flags <= '0;
    else        req_flags <= set_ev | (req_flags & ~clr_hit);
  end

  assign top_valid = |req_flags;

  always_comb begin
    if      (req_flags[4]) top_vector = VEC_NMI;
    else if (req_flags[0]) top_vector = VEC_INT0;
    else if (req_flags[1]) top_vector = VEC_INT1;
    else if (req_flags[2]) top_vector = VEC_INT2;
    else if (req_flags[3]) top_vector = VEC_INT3;
    else                   top_vector = 6'd0;
  end

  AST_QUIET_WARMUP: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> (req_flags == '0)); // R9
  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && mode[1] && s2[0]) |=> req_flags[0]); // R4
  AST_BAD_CLEAR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_wdata[7:6] != 2'b00) |=> (($past(req_flags) & ~req_flags) == '0)); // R7
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_ev & clr_hit)) |=> ((req_flags & $past(set_ev & clr_hit)) == $past(set_ev & clr_hit))); // R8
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit[1] && !set_ev[1]) |=> !req_flags[1]); // R6
  AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    req_flags[4] |-> (top_vector == VEC_NMI)); // R10
  AST_IDLE_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    !top_valid |-> (top_vector == 6'd0 && req_flags == '0)); // R10

endmodule

// File: tb/ext_irq_detect_tb.sv
`timescale 1ns/1ps
module ext_irq_detect_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] irq_in = 4'h1;
  logic       nmi_in = 1'b1;
  logic       cfg_we = 0;
  logic [5:0] cfg_wdata = '0;
  logic       clr_we = 0;
  logic [7:0] clr_wdata = '0;
  logic [4:0] req_flags;
  logic       top_valid;
  logic [5:0] top_vector;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ext_irq_detect dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .nmi_in(nmi_in),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .clr_we(clr_we), .clr_wdata(clr_wdata),
    .req_flags(req_flags), .top_valid(top_valid), .top_vector(top_vector)
  );

  // row: cfg[20:15] irq_a[14:11] nmi_a[10] irq_b[9:6] nmi_b[5] exp[4:0]
  localparam logic [20:0] TBL [8] = '{
    {6'h00, 4'h0, 1'b1, 4'hF, 1'b1, 5'b01111},
    {6'h00, 4'hF, 1'b1, 4'h0, 1'b0, 5'b10000},
    {6'h3C, 4'hF, 1'b0, 4'h0, 1'b0, 5'b01111},
    {6'h3C, 4'h0, 1'b0, 4'hF, 1'b1, 5'b00000},
    {6'h01, 4'h0, 1'b0, 4'h0, 1'b1, 5'b10000},
    {6'h14, 4'h5, 1'b1, 4'h0, 1'b1, 5'b00101},
    {6'h28, 4'h0, 1'b1, 4'h6, 1'b1, 5'b00100},
    {6'h00, 4'hF, 1'b1, 4'h0, 1'b1, 5'b00000}
  };

  function automatic logic [5:0] expect_vec(input logic [4:0] f);
    if (f[4]) return 6'h02;
    for (int i = 0; i < 4; i++) if (f[i]) return 6'h0A + 6'(i);
    return 6'h00;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_flags(input string tag, input logic [4:0] exp);
    chk(tag, {3'b0, req_flags}, {3'b0, exp});
    chk(tag, {2'b0, top_vector}, {2'b0, expect_vec(exp)});
    chk(tag, {7'b0, top_valid}, {7'b0, |exp});
  endtask

  task automatic write_cfg(input logic [5:0] v);
    cfg_we = 1; cfg_wdata = v;
    step(1);
    cfg_we = 0;
  endtask

  task automatic write_clr(input logic [7:0] v);
    clr_we = 1; clr_wdata = v;
    step(1);
    clr_we = 0;
  endtask

  task automatic clear_all();
    write_clr(8'h02); write_clr(8'h0A); write_clr(8'h0B);
    write_clr(8'h0C); write_clr(8'h0D);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    chk_flags("R1 reset state", 5'b00000);
    step(6);
    chk_flags("R9 pin high at reset release", 5'b00000);
    irq_in = 4'h0;
    step(4);
    chk_flags("R9 still quiet", 5'b00000);

    for (int r = 0; r < 8; r++) begin
      write_cfg(TBL[r][20:15]);
      irq_in = TBL[r][14:11]; nmi_in = TBL[r][10];
      step(4);
      clear_all();
      irq_in = TBL[r][9:6]; nmi_in = TBL[r][5];
      step(4);
      chk_flags($sformatf("R3 R5 table row %0d", r), TBL[r][4:0]);
    end

    write_cfg(6'h00);
    irq_in = 4'h0; nmi_in = 1'b1;
    step(4);
    clear_all();
    chk_flags("R6 all cleared", 5'b00000);

    irq_in[1] = 1'b1;
    step(2);
    chk_flags("R2 not yet after two edges", 5'b00000);
    step(1);
    chk_flags("R2 set on third edge", 5'b00010);
    irq_in[1] = 1'b0;
    step(4);
    chk_flags("R11 flag held after pin idle", 5'b00010);
    write_clr(8'h0E);
    chk_flags("R6 unmatched vector ignored", 5'b00010);
    write_clr(8'h0B);
    chk_flags("R6 matching vector clears", 5'b00000);

    irq_in[3] = 1'b1;
    step(3);
    chk_flags("R3 input 3 rising", 5'b01000);
    write_clr(8'h4D);
    chk_flags("R7 upper bit set ignored", 5'b01000);
    write_clr(8'h8D);
    chk_flags("R7 top bit set ignored", 5'b01000);
    write_clr(8'h0D);
    chk_flags("R6 input 3 cleared", 5'b00000);
    irq_in[3] = 1'b0;
    step(4);

    irq_in = 4'b1010;
    step(3);
    chk_flags("R10 input 1 over input 3", 5'b01010);
    nmi_in = 1'b0;
    step(3);
    chk_flags("R10 non-maskable first", 5'b11010);
    write_clr(8'h02);
    chk_flags("R10 back to input 1", 5'b01010);
    write_clr(8'h0B);
    chk_flags("R10 input 3 alone", 5'b01000);
    write_clr(8'h0D);
    chk_flags("R10 none pending", 5'b00000);
    nmi_in = 1'b1;
    step(4);
    chk_flags("R5 rising ignored by default", 5'b00000);
    irq_in = 4'h0;
    step(4);

    irq_in[2] = 1'b1;
    step(3);
    chk_flags("R8 setup flag 2", 5'b00100);
    irq_in[2] = 1'b0;
    step(3);
    irq_in[2] = 1'b1;
    step(2);
    clr_we = 1; clr_wdata = 8'h0C;
    step(1);
    clr_we = 0;
    chk_flags("R8 set wins over clear", 5'b00100);
    write_clr(8'h0C);
    chk_flags("R8 later clear works", 5'b00000);
    irq_in[2] = 1'b0;
    step(4);

    write_cfg(6'h02);
    irq_in[0] = 1'b1;
    step(3);
    chk_flags("R4 level sets flag", 5'b00001);
    write_clr(8'h0A);
    chk_flags("R4 clear blocked while high", 5'b00001);
    step(2);
    chk_flags("R4 still set", 5'b00001);
    irq_in[0] = 1'b0;
    step(3);
    chk_flags("R4 latched after low", 5'b00001);
    write_clr(8'h0A);
    chk_flags("R4 clear after low", 5'b00000);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule